// File: doc/BRIEF.md
# Vendor DMA Setup Request Decoder

This block listens to the control endpoint of a USB device controller. It receives the eight SETUP bytes of a control transfer and then the bytes of the data stage, one byte per strobe. It looks for one fixed vendor request that asks the device to prepare a DMA transfer. When it finds that request, it gathers the six-byte parameter block that follows into four results:

- a 24-bit start address
- a 16-bit transfer size
- a direction
- a start flag

When the parameter block is complete and asks for a start, the block raises `req_valid` for one cycle. The DMA controller and the endpoint logic downstream take the request from this pulse.

If a SETUP packet does not match the signature, the block raises a level stall indication. That level stays high until the next SETUP packet begins. The block does no packet framing, CRC checking or handshake generation. It sees only the byte streams with their strobes.

Top module: `dmareq_decoder`

## Requirements
- R1: A SETUP packet with byte values 0x40, 0x0C, 0x00, 0x00, 0x71, 0x04, 0x06, 0x00 (offsets 0 to 7), followed by six data bytes whose byte 5 has bit 7 set, produces exactly one `req_valid` pulse.
- R2: SETUP fields are read little-endian. The request type is at offset 0 and the request code is at offset 1. The zero value field is at offsets 2–3, the index 0x0471 at offsets 4–5, and the length 6 at offsets 6–7. A byte-swapped index (0x71 at offset 5, 0x04 at offset 4 swapped) does not match.
- R3: `req_addr` is data bytes 0, 1 and 2, placed in bits [7:0], [15:8] and [23:16].
- R4: `req_size` is data byte 3 in bits [7:0] and data byte 4 in bits [15:8]. Sizes from 0x0000 up to 0xFFFF are carried unchanged.
- R5: In data byte 5, bit 7 is the start flag and is reported on `req_start`. Bit 0 is the direction and is reported on `req_dir_in` (1 = IN, 0 = OUT).
- R6: A SETUP packet that differs from the signature in any byte sets `stall` and produces no request. `stall` stays set until the next `setup_first` strobe, which clears it.
- R7: A `setup_first` strobe during a data stage throws away the bytes collected so far. Decoding restarts on the new packet.
- R8: A complete parameter block with bit 7 of byte 5 clear produces no pulse, and all request outputs keep their previous values.
- R9: A data stage shorter than six bytes produces no request.
- R10: `req_valid` lasts one cycle. Between pulses, `req_addr`, `req_size`, `req_dir_in` and `req_start` hold their values.
- R11: A synchronous reset clears all outputs to zero.
- R12: Data bytes that arrive outside an accepted data stage, including any bytes after the sixth, are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| setup_vld | input | 1 | A SETUP byte is present on `setup_byte` |
| setup_first | input | 1 | Marks the first byte of a SETUP packet (qualified by `setup_vld`) |
| setup_byte | input | 8 | SETUP byte |
| data_vld | input | 1 | A data-stage byte is present on `data_byte` |
| data_byte | input | 8 | Data-stage byte |
| req_valid | output | 1 | One-cycle pulse: a new started request is present |
| req_addr | output | 24 | Start address of the request |
| req_size | output | 16 | Transfer size of the request |
| req_dir_in | output | 1 | Direction: 1 = IN, 0 = OUT |
| req_start | output | 1 | Start flag of the last accepted request |
| stall | output | 1 | Control endpoint stall indication |

## Verification
The bench builds the block with its default parameters: three address bytes and two size bytes. These defaults reach the all-ones 24-bit address and the 0xFFFF size, as well as the all-zero boundary. Because the signature length is derived from the parameter block size, the bench's corrupted wLength packet tests the same comparison that sizes the data stage. An expected-request queue catches any stray pulse from:

- short stages
- restarted stages
- stalled requests
- requests with the start flag clear

// File: rtl/dmareq_pkg.sv
package dmareq_pkg;
  localparam int SETUP_BYTES   = 8;
  localparam logic [7:0]  SIG_TYPE  = 8'h40;
  localparam logic [7:0]  SIG_CODE  = 8'h0C;
  localparam logic [15:0] SIG_VALUE = 16'h0000;
  localparam logic [15:0] SIG_INDEX = 16'h0471;
  localparam int CMD_START_BIT = 7;
  localparam int CMD_DIR_BIT   = 0;
endpackage

// File: rtl/dmareq_setup_match.sv
module dmareq_setup_match
  import dmareq_pkg::*;
#(
  parameter int PARAM_BYTES = 6
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       vld,
  input  logic       first,
  input  logic [7:0] byte_in,
  output logic       hit,
  output logic       miss
);
  localparam int CW = $clog2(SETUP_BYTES);
  localparam logic [15:0] SIG_LEN = 16'(PARAM_BYTES);

  logic [CW-1:0] cnt_q;
  logic          active_q;
  logic [7:0]    pkt_q [SETUP_BYTES-1];
  logic          match_c;

  for (genvar i = 0; i < SETUP_BYTES - 1; i++) begin : g_store
    always_ff @(posedge clk) begin
      if (vld && ((first && i == 0) || (!first && active_q && cnt_q == CW'(i))))
        pkt_q[i] <= byte_in;
    end
  end

  always_comb begin
    match_c = (pkt_q[0] == SIG_TYPE)
           && (pkt_q[1] == SIG_CODE)
           && (pkt_q[2] == SIG_VALUE[7:0])
           && (pkt_q[3] == SIG_VALUE[15:8])
           && (pkt_q[4] == SIG_INDEX[7:0])
           && (pkt_q[5] == SIG_INDEX[15:8])
           && (pkt_q[6] == SIG_LEN[7:0])
           && (byte_in  == SIG_LEN[15:8]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      hit      <= 1'b0;
      miss     <= 1'b0;
    end else begin
      hit  <= 1'b0;
      miss <= 1'b0;
      if (vld && first) begin
        cnt_q    <= CW'(1);
        active_q <= 1'b1;
      end else if (vld && active_q) begin
        if (cnt_q == CW'(SETUP_BYTES - 1)) begin
          active_q <= 1'b0;
          cnt_q    <= '0;
          hit      <= match_c;
          miss     <= !match_c;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/dmareq_param_asm.sv
module dmareq_param_asm #(
  parameter int ADDR_BYTES = 3,
  parameter int SIZE_BYTES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    arm,
  input  logic                    abort,
  input  logic                    vld,
  input  logic [7:0]              byte_in,
  output logic                    done,
  output logic [8*ADDR_BYTES-1:0] addr,
  output logic [8*SIZE_BYTES-1:0] size,
  output logic [7:0]              cmd
);
  localparam int NB = ADDR_BYTES + SIZE_BYTES + 1;
  localparam int CW = $clog2(NB);

  logic [CW-1:0] cnt_q;
  logic          busy_q;
  logic [7:0]    blk_q [NB];

  for (genvar i = 0; i < NB; i++) begin : g_blk
    always_ff @(posedge clk) begin
      if (busy_q && vld && cnt_q == CW'(i))
        blk_q[i] <= byte_in;
    end
  end

  for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_addr
    assign addr[8*i +: 8] = blk_q[i];
  end
  for (genvar i = 0; i < SIZE_BYTES; i++) begin : g_size
    assign size[8*i +: 8] = blk_q[ADDR_BYTES + i];
  end
  assign cmd = blk_q[NB-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else if (arm) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q && vld) begin
        if (cnt_q == CW'(NB - 1)) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
          done   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/dmareq_decoder.sv
module dmareq_decoder
  import dmareq_pkg::*;
#(
  parameter int ADDR_BYTES = 3,
  parameter int SIZE_BYTES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    setup_vld,
  input  logic                    setup_first,
  input  logic [7:0]              setup_byte,
  input  logic                    data_vld,
  input  logic [7:0]              data_byte,
  output logic                    req_valid,
  output logic [8*ADDR_BYTES-1:0] req_addr,
  output logic [8*SIZE_BYTES-1:0] req_size,
  output logic                    req_dir_in,
  output logic                    req_start,
  output logic                    stall
);
  localparam int PARAM_BYTES = ADDR_BYTES + SIZE_BYTES + 1;
  localparam int AW = 8 * ADDR_BYTES;
  localparam int SW = 8 * SIZE_BYTES;

  logic          hit, miss, done, restart;
  logic [AW-1:0] asm_addr;
  logic [SW-1:0] asm_size;
  logic [7:0]    asm_cmd;

  assign restart = setup_vld && setup_first;

  dmareq_setup_match #(.PARAM_BYTES(PARAM_BYTES)) match_i (
    .clk(clk), .rst(rst), .vld(setup_vld), .first(setup_first),
    .byte_in(setup_byte), .hit(hit), .miss(miss)
  );

  dmareq_param_asm #(.ADDR_BYTES(ADDR_BYTES), .SIZE_BYTES(SIZE_BYTES)) asm_i (
    .clk(clk), .rst(rst), .arm(hit), .abort(restart), .vld(data_vld),
    .byte_in(data_byte), .done(done), .addr(asm_addr), .size(asm_size),
    .cmd(asm_cmd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid  <= 1'b0;
      req_addr   <= '0;
      req_size   <= '0;
      req_dir_in <= 1'b0;
      req_start  <= 1'b0;
      stall      <= 1'b0;
    end else begin
      req_valid <= 1'b0;
      if (restart)   stall <= 1'b0;
      else if (miss) stall <= 1'b1;
      if (done && asm_cmd[CMD_START_BIT]) begin
        req_valid  <= 1'b1;
        req_addr   <= asm_addr;
        req_size   <= asm_size;
        req_dir_in <= asm_cmd[CMD_DIR_BIT];
        req_start  <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dmareq_decoder_chk.sv
module dmareq_decoder_chk #(
  parameter int ADDR_BYTES = 3,
  parameter int SIZE_BYTES = 2
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    setup_vld,
  input logic                    setup_first,
  input logic                    req_valid,
  input logic [8*ADDR_BYTES-1:0] req_addr,
  input logic [8*SIZE_BYTES-1:0] req_size,
  input logic                    req_dir_in,
  input logic                    req_start,
  input logic                    stall
);
  logic seen = 1'b0;
  always_ff @(posedge clk) if (rst) seen <= 1'b1;

  p_single_pulse_r10: assert property (@(posedge clk) disable iff (rst || !seen)
    req_valid |=> !req_valid);

  p_hold_fields_r10: assert property (@(posedge clk) disable iff (rst || !seen)
    (!req_valid && !$past(rst)) |-> ($stable(req_addr) && $stable(req_size)
                                     && $stable(req_dir_in) && $stable(req_start)));

  p_start_flag_r5: assert property (@(posedge clk) disable iff (rst || !seen)
    req_valid |-> req_start);

  p_no_req_when_stalled_r6: assert property (@(posedge clk) disable iff (rst || !seen)
    req_valid |-> !stall);

  p_stall_cleared_r6: assert property (@(posedge clk) disable iff (rst || !seen)
    (setup_vld && setup_first) |=> !stall);

  p_reset_clear_r11: assert property (@(posedge clk) disable iff (rst || !seen)
    $past(rst) |-> (!req_valid && !stall && req_addr == '0 && req_size == '0
                    && !req_start && !req_dir_in));
endmodule

bind dmareq_decoder dmareq_decoder_chk #(.ADDR_BYTES(ADDR_BYTES), .SIZE_BYTES(SIZE_BYTES)) chk_i (
  .clk(clk), .rst(rst), .setup_vld(setup_vld), .setup_first(setup_first),
  .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
  .req_dir_in(req_dir_in), .req_start(req_start), .stall(stall)
);

// File: tb/dmareq_decoder_tb_top.sv
module dmareq_decoder_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        setup_vld = 1'b0, setup_first = 1'b0, data_vld = 1'b0;
  logic [7:0]  setup_byte = '0, data_byte = '0;
  logic        req_valid, req_dir_in, req_start, stall;
  logic [23:0] req_addr;
  logic [15:0] req_size;

  int checks = 0;
  int errors = 0;
  logic [40:0] exp_q [$];
  logic        prev_valid = 1'b0;

  localparam logic [63:0] GOOD = 64'h0006_0471_0000_0C40;

  always #10 clk = ~clk;

  dmareq_decoder dut_i (
    .clk(clk), .rst(rst), .setup_vld(setup_vld), .setup_first(setup_first),
    .setup_byte(setup_byte), .data_vld(data_vld), .data_byte(data_byte),
    .req_valid(req_valid), .req_addr(req_addr), .req_size(req_size),
    .req_dir_in(req_dir_in), .req_start(req_start), .stall(stall)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pops an expected request on every pulse
  always @(negedge clk) begin
    if (!rst && req_valid) begin
      logic [40:0] got;
      got = {req_dir_in, req_size, req_addr};
      if (prev_valid) check(1'b0, "R10 pulse width", 64'd2, 64'd1);
      if (exp_q.size() == 0) check(1'b0, "R1 unexpected request", 64'(got), 64'd0);
      else begin
        logic [40:0] e;
        e = exp_q.pop_front();
        check(got == e, "R1 R3 R4 R5 request fields", 64'(got), 64'(e));
        check(req_start == 1'b1, "R5 start flag", 64'(req_start), 64'd1);
      end
    end
    prev_valid = req_valid;
  end

  task automatic send_setup(input logic [63:0] pkt);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      setup_vld = 1'b1; setup_first = (i == 0); setup_byte = pkt[8*i +: 8];
    end
    @(negedge clk);
    setup_vld = 1'b0; setup_first = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_data(input logic [63:0] d, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      data_vld = 1'b1; data_byte = d[8*i +: 8];
    end
    @(negedge clk);
    data_vld = 1'b0;
  endtask

  task automatic request(input logic [23:0] a, input logic [15:0] s, input logic [7:0] c);
    if (c[7]) exp_q.push_back({c[0], s, a});
    send_setup(GOOD);
    send_data({16'h0, c, s, a}, 6);
    repeat (4) @(negedge clk);
  endtask

  task automatic check_stall(input logic [63:0] pkt, input string req);
    send_setup(pkt);
    repeat (2) @(negedge clk);
    check(stall == 1'b1, req, 64'(stall), 64'd1);
    send_data(64'h81_0010_000001, 6);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    check(1'b0, "watchdog", 64'd0, 64'd1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({req_valid, req_addr, req_size, req_dir_in, req_start, stall} == '0,
          "R11 reset state", 64'(req_addr), 64'd0);

    request(24'h123456, 16'h0040, 8'h81);                  // R1 R3 R4 R5
    request(24'hFFFFFF, 16'hFFFF, 8'h80);                  // R4 max size, OUT
    request(24'h000000, 16'h0000, 8'h81);                  // R3 R4 zero boundary
    check(req_addr == 24'h0 && req_size == 16'h0 && req_dir_in,
          "R10 hold after request", 64'(req_addr), 64'd0);

    check_stall(64'h0006_0471_0000_0C41, "R6 stall on bad type");
    check_stall(64'h0006_0471_0000_0D40, "R6 stall on bad code");
    check_stall(64'h0006_7104_0000_0C40, "R2 stall on swapped index");
    check_stall(64'h0005_0471_0000_0C40, "R2 stall on bad length");
    check_stall(64'h0006_0471_0100_0C40, "R2 stall on nonzero value");

    send_setup(GOOD);
    check(stall == 1'b0, "R6 stall cleared by new SETUP", 64'(stall), 64'd0);
    send_data(64'h01_0200_ABCDEF, 6);                      // R8 start bit clear
    repeat (4) @(negedge clk);
    check(req_addr == 24'h0 && req_size == 16'h0 && req_dir_in == 1'b1,
          "R8 outputs unchanged", 64'(req_addr), 64'd0);

    send_setup(GOOD);                                      // R9 short stage
    send_data(64'h81_0300_111111, 4);
    repeat (4) @(negedge clk);
    check(req_addr == 24'h0, "R9 short stage no request", 64'(req_addr), 64'd0);

    send_setup(GOOD);                                      // R7 restart mid stage
    send_data(64'h81_0300_222222, 3);
    exp_q.push_back({1'b0, 16'h1234, 24'h345678});
    send_setup(GOOD);
    send_data(64'hFF_FF_80_1234_345678, 8);                // R12 extra bytes ignored
    repeat (4) @(negedge clk);
    check(req_addr == 24'h345678 && req_size == 16'h1234 && !req_dir_in,
          "R7 R12 fields after restart", 64'(req_addr), 64'h345678);

    send_data(64'h81_0001_999999, 6);                      // R12 no accepted stage
    repeat (4) @(negedge clk);
    check(req_addr == 24'h345678, "R12 stray data ignored", 64'(req_addr), 64'h345678);

    check(exp_q.size() == 0, "R1 all expected requests seen", 64'(exp_q.size()), 64'd0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule